// File: doc/BRIEF.md
# Bit-Sliced Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit. It is built from a chain of identical one-bit slices, eight by default. Each slice first conditions its two operand bits. Each operand can be forced to zero, and the first operand can then be complemented. The slice then picks one of four results with a function code that is decoded locally inside the slice.

The four results are a bitwise AND, a bitwise OR, the complement of the second operand, and a full-adder sum. In the sum function, each slice passes its carry to the slice above it. A separate increment input feeds the carry into the lowest slice.

The operand controls let one datapath produce several useful results without extra adders: pass-through, negation, increment and decrement. For example, with the first operand removed and complemented, the sum function adds all ones to the second operand. The result is the second operand minus one.

Top module: `sliced_alu`

## Requirements
- R1: With `fsel` = 2'b00, `result` equals the bitwise AND of the conditioned operands.
- R2: With `fsel` = 2'b01, `result` equals the bitwise OR of the conditioned operands.
- R3: With `fsel` = 2'b10, `result` equals the bitwise complement of the conditioned second operand.
- R4: With `fsel` = 2'b11, `result` is the low WIDTH bits of (conditioned A + conditioned B + `inc_in`), and `carry_out` is bit WIDTH of that sum.
- R5: When `en_a` is 0, the A operand is forced to all zeros before any inversion.
- R6: When `en_b` is 0, the B operand is forced to all zeros in every function.
- R7: When `inv_a` is 1, the A operand is complemented after the enable and before the logic and the adder.
- R8: `inc_in` is the carry into bit 0. It changes the result only when `fsel` = 2'b11.
- R9: For `fsel` values 2'b00, 2'b01 and 2'b10, `carry_out` is 0.
- R10: With `en_a`=0, `inv_a`=1, `en_b`=1, `fsel`=2'b11 and `inc_in`=0, `result` equals `opb` minus 1 modulo 2^WIDTH.
- R11: The carry ripples through every slice. With A = all ones, B = 0 and `inc_in` = 1 in the sum function, `result` is 0 and `carry_out` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| fsel | input | 2 | Function code: 00 AND, 01 OR, 10 NOT B, 11 sum |
| en_a | input | 1 | Enable for the first operand; when 0 the operand is zero |
| en_b | input | 1 | Enable for the second operand; when 0 the operand is zero |
| inv_a | input | 1 | Complements the enabled first operand |
| inc_in | input | 1 | Carry into the lowest slice |
| result | output | WIDTH | Word result |
| carry_out | output | 1 | Carry out of the top slice; 0 outside the sum function |

## Verification
The bench builds the block at its default width of eight slices. At that width, the full-scale boundary operands can be hit directly: all ones, zero and the sign bit. These include the wrap of the decrement case and a carry that crosses every slice. Eight bits also keep a sweep over all 64 combinations of function code and operand controls affordable, with several operand pairs for each combination. That sweep places every slice's function decoder and every carry link under each control setting.

// File: rtl/alu_pkg.sv
package alu_pkg;

  // Function code width and derived count of decoded functions
  localparam int FUNC_W   = 2;
  localparam int NUM_FUNC = 1 << FUNC_W;

  // Code values are part of the block's interface
  typedef enum logic [FUNC_W-1:0] {
    FN_AND  = 2'b00,
    FN_OR   = 2'b01,
    FN_NOTB = 2'b10,
    FN_ADD  = 2'b11
  } alu_fn_e;

endpackage

// File: rtl/alu_func_decode.sv
module alu_func_decode
  import alu_pkg::*;
(
  input  logic [FUNC_W-1:0]   code,
  output logic [NUM_FUNC-1:0] hot
);

  // One select line per function code
  for (genvar g = 0; g < NUM_FUNC; g++) begin : g_line
    assign hot[g] = (code == FUNC_W'(g));
  end

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic              a_bit,
  input  logic              b_bit,
  input  logic              en_a,
  input  logic              en_b,
  input  logic              inv_a,
  input  logic [FUNC_W-1:0] fsel,
  input  logic              c_in,
  output logic              r_bit,
  output logic              c_out
);

  logic [NUM_FUNC-1:0] sel_hot;
  logic                a_op;
  logic                b_op;
  logic                and_t;
  logic                or_t;
  logic                notb_t;
  logic                sum_t;
  logic                gen_c;

  alu_func_decode u_dec (
    .code (fsel),
    .hot  (sel_hot)
  );

  // Operand conditioning: gate first, then optional invert of A
  always_comb begin
    a_op = (a_bit & en_a) ^ inv_a;
    b_op = b_bit & en_b;
  end

  // Logic unit and full adder
  always_comb begin
    and_t  = a_op & b_op;
    or_t   = a_op | b_op;
    notb_t = ~b_op;
    sum_t  = a_op ^ b_op ^ c_in;
    gen_c  = (a_op & b_op) | (c_in & (a_op ^ b_op));
  end

  // Output select from decoded lines
  always_comb begin
    r_bit = (sel_hot[FN_AND]  & and_t)
          | (sel_hot[FN_OR]   & or_t)
          | (sel_hot[FN_NOTB] & notb_t)
          | (sel_hot[FN_ADD]  & sum_t);
    c_out = sel_hot[FN_ADD] & gen_c;
  end

  // Assertions guarding the decoder and the carry gating
  always_comb begin
    p_one_func_r4: assert ($onehot(sel_hot))
      else $error("decoded function lines not one-hot: %b", sel_hot);
    if (fsel != FN_ADD) begin
      p_carry_zero_r9: assert (c_out == 1'b0)
        else $error("carry asserted outside sum function");
    end
    if (!en_b) begin
      p_b_gated_r6: assert (fsel != FN_NOTB || r_bit == 1'b1)
        else $error("disabled B not zero under NOT B");
    end
  end

endmodule

// File: rtl/sliced_alu.sv
module sliced_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]  opa,
  input  logic [WIDTH-1:0]  opb,
  input  logic [FUNC_W-1:0] fsel,
  input  logic              en_a,
  input  logic              en_b,
  input  logic              inv_a,
  input  logic              inc_in,
  output logic [WIDTH-1:0]  result,
  output logic              carry_out
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  // carry_link[k] enters slice k; carry_link[WIDTH] leaves the top
  logic [WIDTH:0] carry_link;

  assign carry_link[0] = inc_in;

  for (genvar k = 0; k < WIDTH; k++) begin : g_slice
    alu_bit_slice u_slice (
      .a_bit (opa[k]),
      .b_bit (opb[k]),
      .en_a  (en_a),
      .en_b  (en_b),
      .inv_a (inv_a),
      .fsel  (fsel),
      .c_in  (carry_link[k]),
      .r_bit (result[k]),
      .c_out (carry_link[k+1])
    );
  end

  assign carry_out = carry_link[WIDTH];

  // Word-level checks on the assembled slice chain
  always_comb begin
    if (fsel == FN_ADD && !en_a && inv_a && en_b && !inc_in) begin
      p_decrement_r10: assert (result == opb - WIDTH'(1))
        else $error("decrement mismatch: %h for %h", result, opb);
    end
    if (fsel == FN_ADD && !en_a && !inv_a && !en_b) begin
      p_inc_only_r8: assert (result == WIDTH'(inc_in) && carry_out == 1'b0)
        else $error("zero operands did not yield the carry in");
    end
    if (fsel == FN_ADD && en_a && !inv_a && !en_b && !inc_in) begin
      p_pass_a_r6: assert (result == opa && !carry_out)
        else $error("A pass-through mismatch");
    end
    if (fsel == FN_AND && !en_a && !inv_a) begin
      p_a_gated_r5: assert (result == '0)
        else $error("disabled A leaked into AND");
    end
    if (fsel == FN_ADD && en_a && !inv_a && !en_b && inc_in && opa == ALL_ONES) begin
      p_full_ripple_r11: assert (result == '0 && carry_out)
        else $error("carry did not ripple through all slices");
    end
  end

endmodule

// File: tb/sliced_alu_tb_top.sv
module sliced_alu_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WIDTH      = 8;
  localparam int WDOG_CYC   = 100000;

  logic             clk;
  logic             rst_n;
  logic [WIDTH-1:0] opa;
  logic [WIDTH-1:0] opb;
  logic [1:0]       fsel;
  logic             en_a;
  logic             en_b;
  logic             inv_a;
  logic             inc_in;
  logic [WIDTH-1:0] result;
  logic             carry_out;

  int n_vec;
  int n_bad;
  bit done;

  sliced_alu #(.WIDTH(WIDTH)) dut_i (
    .opa       (opa),
    .opb       (opb),
    .fsel      (fsel),
    .en_a      (en_a),
    .en_b      (en_b),
    .inv_a     (inv_a),
    .inc_in    (inc_in),
    .result    (result),
    .carry_out (carry_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model built from the requirements
  function automatic logic [WIDTH:0] model(
    logic [WIDTH-1:0] a, logic [WIDTH-1:0] b, logic [1:0] f,
    logic ea, logic eb, logic ia, logic ci);
    logic [WIDTH-1:0] ac, bc;
    logic [WIDTH:0]   s;
    ac = (ea ? a : '0) ^ {WIDTH{ia}};
    bc = eb ? b : '0;
    case (f)
      2'b00:   model = {1'b0, ac & bc};
      2'b01:   model = {1'b0, ac | bc};
      2'b10:   model = {1'b0, ~bc};
      default: begin
        s = {1'b0, ac} + {1'b0, bc} + (WIDTH+1)'(ci);
        model = s;
      end
    endcase
  endfunction

  // Drive on the falling edge, compare before the next rising edge
  task automatic apply(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                       input logic [1:0] f, input logic ea, input logic eb,
                       input logic ia, input logic ci);
    @(negedge clk);
    opa = a; opb = b; fsel = f; en_a = ea; en_b = eb; inv_a = ia; inc_in = ci;
    #(CLK_PERIOD/4);
  endtask

  task automatic expect_out(input string req, input logic [WIDTH-1:0] exp_r,
                            input logic exp_c);
    n_vec++;
    if (result !== exp_r || carry_out !== exp_c) begin
      n_bad++;
      $display("FAIL %s: result=%h carry=%b expected result=%h carry=%b",
               req, result, carry_out, exp_r, exp_c);
    end
  endtask

  task automatic check_model(input string req);
    logic [WIDTH:0] m;
    m = model(opa, opb, fsel, en_a, en_b, inv_a, inc_in);
    expect_out(req, m[WIDTH-1:0], m[WIDTH]);
  endtask

  task automatic t_idle;
    // All inputs low: AND of zero operands
    apply('0, '0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
    expect_out("R1 idle", 8'h00, 1'b0);
  endtask

  task automatic t_logic;
    apply(8'hC3, 8'hA5, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
    expect_out("R1", 8'h81, 1'b0);
    apply(8'hC3, 8'hA5, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0);
    expect_out("R2", 8'hE7, 1'b0);
    apply(8'hC3, 8'hA5, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0);
    expect_out("R3", 8'h5A, 1'b0);
  endtask

  task automatic t_add;
    apply(8'h7F, 8'h01, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0);
    expect_out("R4", 8'h80, 1'b0);
    apply(8'hF0, 8'h20, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1);
    expect_out("R4 carry", 8'h11, 1'b1);
  endtask

  task automatic t_enables;
    apply(8'hFF, 8'h3C, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0);
    expect_out("R5", 8'h3C, 1'b0);
    apply(8'h55, 8'hFF, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0);
    expect_out("R6", 8'hFF, 1'b0);
    apply(8'h0F, 8'hFF, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0);
    expect_out("R7 after enable", 8'hFF, 1'b0);
    apply(8'h0F, 8'hFF, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0);
    expect_out("R7", 8'hF0, 1'b0);
  endtask

  task automatic t_inc;
    apply(8'h00, 8'h00, 2'b11, 1'b0, 1'b0, 1'b0, 1'b1);
    expect_out("R8 sum", 8'h01, 1'b0);
    apply(8'h12, 8'h34, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1);
    expect_out("R8 ignored in OR", 8'h36, 1'b0);
  endtask

  task automatic t_carry_zero;
    apply(8'hFF, 8'hFF, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1);
    expect_out("R9 AND", 8'hFF, 1'b0);
    apply(8'hFF, 8'hFF, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1);
    expect_out("R9 OR", 8'hFF, 1'b0);
    apply(8'hFF, 8'h00, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1);
    expect_out("R9 NOTB", 8'hFF, 1'b0);
  endtask

  task automatic t_decrement;
    apply(8'h99, 8'h40, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0);
    expect_out("R10", 8'h3F, 1'b1);
    apply(8'h99, 8'h00, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0);
    expect_out("R10 wrap", 8'hFF, 1'b0);
  endtask

  task automatic t_ripple;
    apply(8'hFF, 8'h00, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1);
    expect_out("R11", 8'h00, 1'b1);
  endtask

  task automatic t_sweep;
    logic [WIDTH-1:0] pats [6];
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'h80;
    pats[3] = 8'h55; pats[4] = 8'h01; pats[5] = 8'h7E;
    for (int c = 0; c < 64; c++) begin
      for (int p = 0; p < 8; p++) begin
        logic [WIDTH-1:0] a, b;
        a = (p < 6) ? pats[p] : WIDTH'($urandom);
        b = (p < 6) ? pats[5-p] : WIDTH'($urandom);
        apply(a, b, c[1:0], c[2], c[3], c[4], c[5]);
        // R1 R2 R3 R4 R5 R6 R7 R8 R9 across all control settings
        check_model("R4 sweep");
      end
    end
  endtask

  initial begin
    rst_n = 1'b0;
    n_vec = 0; n_bad = 0; done = 1'b0;
    opa = '0; opb = '0; fsel = '0; en_a = 0; en_b = 0; inv_a = 0; inc_in = 0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_logic();
    t_add();
    t_enables();
    t_inc();
    t_carry_zero();
    t_decrement();
    t_ripple();
    t_sweep();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule